// File: doc/BRIEF.md
# Bus Master Retry Limit Controller

This block carries one host transaction at a time onto a simple target-side handshake. It presents each attempt to the target as a single-cycle strobe. When the target answers "retry", it issues the same attempt again. It gives up once a programmable retry budget is spent. When the transfer ends, the host receives a one-cycle completion that carries read data and an abort flag.

The retry budget sits in an 8-bit limit register, which software reaches through a 32-bit configuration write/read port with byte enables. A limit of zero turns the time-out off. Any other value N allows N retries after the first attempt. A read that ends by time-out returns all-ones data instead of an error. Both the system reset and a separate synchronous bus reset clear the limit. Configuration writes that arrive while a transfer is outstanding are dropped, so the budget cannot change under a live transaction.

The sequencer has four states:
- `ST_IDLE`: ready for a request.
- `ST_ISSUE`: the attempt strobe is high.
- `ST_WAIT`: waiting for the target response.
- `ST_COMPLETE`: the completion pulse.

Its transitions are:
- IDLE→ISSUE when a request is accepted.
- ISSUE→WAIT on the next cycle, always.
- WAIT→ISSUE on a retry response while budget remains.
- WAIT→COMPLETE on a done response, or on a retry response once the budget is spent.
- COMPLETE→IDLE on the next cycle, always.

Top module: `retry_limit_ctrl`

## Requirements
- R1: After system reset the limit reads 0, `req_ready` is 1, and `att_strobe` and `cpl_valid` are 0.
- R2: With limit 0, every retry response leads to a new attempt without bound. A done response completes with `cpl_abort`=0, and for a read `cpl_rdata` equals the target's `tgt_rdata`.
- R3: With limit N≠0, the target sees at most N+1 attempts. A retry response to attempt N+1 ends the transfer with `cpl_abort`=1, and with fewer retries the transfer completes normally.
- R4: An aborted read completes with `cpl_rdata`=FFFFFFFFh. Any write completion, aborted or not, carries `cpl_rdata`=0.
- R5: A high `bus_rst` at a clock edge clears the limit to 0 from the next cycle on.
- R6: A configuration write at a clock edge where `req_ready` is 0 leaves the limit unchanged.
- R7: The limit occupies bits 15:8 of the configuration word. A write updates it only when `cfg_be[1]` is 1, and all other read bits are 0.
- R8: `att_strobe` is high for exactly one cycle per attempt. `att_addr`, `att_write` and `att_wdata` hold the accepted request's values across every attempt of a transfer.
- R9: A request is accepted only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance through the completion cycle, and `cpl_valid` lasts one cycle.
- R10: The first strobe appears the cycle after acceptance. After a retry response, the next strobe follows in the next cycle. After a final response, `cpl_valid` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_rst | input | 1 | Synchronous bus reset, clears the limit |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | One-cycle completion strobe |
| cpl_abort | output | 1 | Completion ended by time-out |
| cpl_rdata | output | 32 | Completion read data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (limit in 15:8) |
| att_strobe | output | 1 | One-cycle attempt strobe |
| att_write | output | 1 | Attempt direction |
| att_addr | output | 32 | Attempt address |
| att_wdata | output | 32 | Attempt write data |
| tgt_resp_valid | input | 1 | Target response valid |
| tgt_retry | input | 1 | Response is retry (1) or done (0) |
| tgt_rdata | input | 32 | Target read data with done |

## Verification
The strobe for the first attempt is due one cycle after the acceptance edge, since one state register lies between them. A retry response brings the next strobe one cycle later, and a final response brings the completion one cycle later. The bench drives every input on the falling edge and samples one falling edge after the edge that should move the design. At each such point it checks that the strobe or completion is present or absent as the model predicts. Configuration effects are read back one cycle after the write edge, and the limit is checked again after each transfer to confirm it did not move.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_COMPLETE
    } rlc_state_e;

    typedef struct packed {
        logic        write;
        logic [31:0] addr;
        logic [31:0] wdata;
    } rlc_req_t;
endpackage

// File: rtl/rlc_limit_reg.sv
module rlc_limit_reg #(
    parameter int LIMIT_W = 8,
    parameter int CFG_W   = 32,
    parameter int LANE    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic               busy,
    input  logic               cfg_wr,
    input  logic [CFG_W/8-1:0] cfg_be,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic [LIMIT_W-1:0] limit
);
    localparam int LO = LANE * 8;

    logic [LIMIT_W-1:0] limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (bus_rst) begin
            limit_q <= '0;
        end else if (cfg_wr && cfg_be[LANE] && !busy) begin
            limit_q <= cfg_wdata[LO +: LIMIT_W];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[LO +: LIMIT_W] = limit_q;
    end

    assign limit = limit_q;
endmodule

// File: rtl/rlc_retry_ctr.sv
module rlc_retry_ctr #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               bump,
    input  logic [LIMIT_W-1:0] limit,
    output logic               spent
);
    logic [LIMIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // budget used up: the retries already granted equal the limit
    assign spent = (limit != '0) && (cnt_q == limit);
endmodule

// File: rtl/rlc_seq.sv
module rlc_seq
    import rlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       tgt_resp_valid,
    input  logic       tgt_retry,
    input  logic       spent,
    output rlc_state_e state,
    output logic       accept,
    output logic       retry_take,
    output logic       end_ok,
    output logic       end_abort
);
    rlc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        retry_take = 1'b0;
        end_ok     = 1'b0;
        end_abort  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (tgt_resp_valid) begin
                    if (!tgt_retry) begin
                        end_ok  = 1'b1;
                        state_d = ST_COMPLETE;
                    end else if (spent) begin
                        end_abort = 1'b1;
                        state_d   = ST_COMPLETE;
                    end else begin
                        retry_take = 1'b1;
                        state_d    = ST_ISSUE;
                    end
                end
            end
            ST_COMPLETE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/retry_limit_ctrl.sv
module retry_limit_ctrl
    import rlc_pkg::*;
#(
    parameter int LIMIT_W = 8,
    parameter int DATA_W  = 32,
    parameter int CFG_W   = 32,
    parameter int LANE    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpl_valid,
    output logic              cpl_abort,
    output logic [DATA_W-1:0] cpl_rdata,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              att_strobe,
    output logic              att_write,
    output logic [31:0]       att_addr,
    output logic [DATA_W-1:0] att_wdata,
    input  logic              tgt_resp_valid,
    input  logic              tgt_retry,
    input  logic [DATA_W-1:0] tgt_rdata
);
    rlc_state_e         state;
    logic               accept, retry_take, end_ok, end_abort, spent, busy;
    logic [LIMIT_W-1:0] limit;
    logic               wr_q;
    logic [31:0]        addr_q;
    logic [DATA_W-1:0]  wdata_q, cdata_q;
    logic               cabort_q;

    assign busy = (state != ST_IDLE);

    rlc_limit_reg #(.LIMIT_W(LIMIT_W), .CFG_W(CFG_W), .LANE(LANE)) u_limit (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .busy(busy),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .limit(limit)
    );

    rlc_retry_ctr #(.LIMIT_W(LIMIT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(accept), .bump(retry_take),
        .limit(limit), .spent(spent)
    );

    rlc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .tgt_resp_valid(tgt_resp_valid), .tgt_retry(tgt_retry), .spent(spent),
        .state(state), .accept(accept), .retry_take(retry_take),
        .end_ok(end_ok), .end_abort(end_abort)
    );

    // request hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // completion capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cdata_q  <= '0;
            cabort_q <= 1'b0;
        end else if (end_ok) begin
            cdata_q  <= wr_q ? '0 : tgt_rdata;
            cabort_q <= 1'b0;
        end else if (end_abort) begin
            cdata_q  <= wr_q ? '0 : '1;
            cabort_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        att_strobe = (state == ST_ISSUE);
        cpl_valid  = (state == ST_COMPLETE);
        cpl_abort  = cabort_q;
        cpl_rdata  = cdata_q;
        att_write  = wr_q;
        att_addr   = addr_q;
        att_wdata  = wdata_q;
    end
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rst,
    input logic        req_ready,
    input logic        cpl_valid,
    input logic        cpl_abort,
    input logic [31:0] cpl_rdata,
    input logic [31:0] cfg_rdata,
    input logic        att_strobe,
    input logic        att_write,
    input logic [31:0] att_addr,
    input logic [31:0] att_wdata
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        att_strobe |=> !att_strobe); // R8
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        att_strobe |-> !req_ready); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(att_addr) && $stable(att_write) && $stable(att_wdata))); // R8
    AST_CPL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid); // R9
    AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_abort && !att_write) |-> (cpl_rdata == 32'hFFFF_FFFF)); // R4
    AST_BUSRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (cfg_rdata == 32'h0)); // R5
    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !bus_rst) |=> $stable(cfg_rdata)); // R6
endmodule

bind retry_limit_ctrl rlc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .req_ready(req_ready),
    .cpl_valid(cpl_valid), .cpl_abort(cpl_abort), .cpl_rdata(cpl_rdata),
    .cfg_rdata(cfg_rdata), .att_strobe(att_strobe), .att_write(att_write),
    .att_addr(att_addr), .att_wdata(att_wdata)
);

// File: tb/retry_limit_ctrl_test.sv
module retry_limit_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_rst = 0;
    logic        req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic        req_ready, cpl_valid, cpl_abort;
    logic [31:0] cpl_rdata, cfg_rdata;
    logic        cfg_wr = 0;
    logic [3:0]  cfg_be = 0;
    logic [31:0] cfg_wdata = 0;
    logic        att_strobe, att_write;
    logic [31:0] att_addr, att_wdata;
    logic        tgt_resp_valid = 0, tgt_retry = 0;
    logic [31:0] tgt_rdata = 0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    retry_limit_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cpl_valid(cpl_valid), .cpl_abort(cpl_abort), .cpl_rdata(cpl_rdata),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .att_strobe(att_strobe), .att_write(att_write), .att_addr(att_addr),
        .att_wdata(att_wdata), .tgt_resp_valid(tgt_resp_valid),
        .tgt_retry(tgt_retry), .tgt_rdata(tgt_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_abort(input int lim, input int nretry);
        return (lim != 0) && (nretry > lim);
    endfunction

    function automatic logic [31:0] exp_data(input bit wr, input bit ab, input logic [31:0] td);
        if (wr) return 32'h0;
        return ab ? 32'hFFFF_FFFF : td;
    endfunction

    task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0; cfg_be = 0;
    endtask

    // one transfer: target answers retry nretry times, then done
    task automatic txn(input int lim, input bit wr, input int nretry, input bit poke_cfg);
        logic [31:0] a, wd, td, lim_before;
        int tries;
        bit ab, go_on;
        a = $urandom; wd = $urandom; td = $urandom;
        ab = exp_abort(lim, nretry);
        lim_before = cfg_rdata;
        @(negedge clk);
        check("R9 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_addr = $urandom; req_wdata = $urandom; req_write = ~wr;
        check("R10 first strobe after accept", {31'b0, att_strobe}, 32'd1);
        check("R9 ready low while busy", {31'b0, req_ready}, 32'd0);
        if (poke_cfg) begin
            cfg_wr = 1; cfg_be = 4'hF; cfg_wdata = 32'h0000_5A00;
        end
        tries = 0;
        go_on = 1;
        while (go_on) begin
            @(negedge clk);
            cfg_wr = 0; cfg_be = 0;
            check("R8 strobe single cycle", {31'b0, att_strobe}, 32'd0);
            check("R8 address held", att_addr, a);
            tgt_resp_valid = 1;
            tgt_retry = (tries < nretry);
            tgt_rdata = td;
            go_on = (tries < nretry) && !(lim != 0 && tries == lim);
            @(negedge clk);
            tgt_resp_valid = 0; tgt_retry = 0; tgt_rdata = $urandom;
            if (go_on) begin
                tries++;
                check("R2/R3 retry re-issued (R10)", {31'b0, att_strobe}, 32'd1);
                check("R3 no early completion", {31'b0, cpl_valid}, 32'd0);
            end
        end
        check("R10 completion after final response", {31'b0, cpl_valid}, 32'd1);
        check("R3 abort flag", {31'b0, cpl_abort}, {31'b0, ab});
        check("R4 completion data (R2)", cpl_rdata, exp_data(wr, ab, td));
        check("R8 write data held", att_wdata, wd);
        @(negedge clk);
        check("R9 completion one cycle", {31'b0, cpl_valid}, 32'd0);
        check("R6 limit unchanged after busy write", cfg_rdata, lim_before);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 limit after reset", cfg_rdata, 32'h0);
        check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        check("R1 no strobe after reset", {31'b0, att_strobe}, 32'd0);
        check("R1 no completion after reset", {31'b0, cpl_valid}, 32'd0);
        rst_n = 1;

        // R7: lane behaviour
        cfg_write(4'b1101, 32'hFFFF_FFFF);
        check("R7 lane1 disabled no change", cfg_rdata, 32'h0);
        cfg_write(4'b0010, 32'hABCD_0312);
        check("R7 lane1 write, others zero", cfg_rdata, 32'h0000_0300);

        // R5: bus reset
        @(negedge clk); bus_rst = 1;
        @(negedge clk); bus_rst = 0;
        check("R5 bus reset clears limit", cfg_rdata, 32'h0);

        // R2: limit zero, many retries
        txn(0, 0, 20, 0);
        txn(0, 1, 0, 1);
        // R3 boundaries with limit 2
        cfg_write(4'b0010, 32'h0000_0200);
        txn(2, 0, 2, 0);   // exactly N retries: completes
        txn(2, 0, 3, 1);   // one more: aborts, read ones (R4)
        txn(2, 1, 7, 0);   // aborted write, data 0 (R4)
        cfg_write(4'b0010, 32'h0000_0100);
        txn(1, 0, 1, 0);
        txn(1, 0, 2, 0);

        // random mix
        for (int i = 0; i < 150; i++) begin
            int lim, nr;
            case ($urandom_range(0, 3))
                0: lim = 0;
                1: lim = 1;
                2: lim = $urandom_range(2, 6);
                default: lim = $urandom_range(0, 255);
            endcase
            cfg_write(4'b0010, lim << 8);
            check("R7 limit readback", cfg_rdata, lim << 8);
            nr = $urandom_range(0, 9);
            txn(lim, $urandom_range(0, 1), nr, $urandom_range(0, 1));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule